// File: doc/BRIEF.md
# Microcycle phase sequencer

This block paces each control-store cycle of a microprogrammed machine. A cycle is split into fifteen sub-cycle phases, called a through o. The sequencer visits them in order and moves one phase on each clock edge where the advance enable is high. It publishes its position in two ways:

- three active-low cycle-control lines, whose combined pattern tells downstream strobe logic which part of the cycle is under way;
- a one-hot phase vector, kept for debug visibility.

An active-low terminate request can cut a cycle short. It sends the sequencer back to phase a on the next enabled edge. An end-of-cycle pulse marks every return to phase a, whether it comes from a full cycle or from a terminated one.

The code carried by the three lines is chosen so that a normal step never changes more than one line. This also holds for the wrap from o back to a. Downstream decoders therefore never see two lines switching together, which would let them read a pattern that lies between two phases. All control pins are plain levels. There is no data path, so there is no handshake.

Top module: `mcycle_seq`

## Requirements
- R1: While `rst` is high at a clock edge, the sequencer enters phase a. After that edge:
  - `phase_oh` equals 15'h0001;
  - `cc_n` equals 3'b111;
  - `cycle_end` is 0.
- R2: On a clock edge where `adv_en` is low, the phase does not change and `cycle_end` is 0 in the following cycle.
- R3: On an enabled edge with `term_n` high, the phase moves to the next one in order a,b,...,o, and from o it wraps to a. Phase a through o is held in `phase_oh` bit 0 through bit 14.
- R4: Line 1 is `cc_n[0]`. It is low in phases b, c, d, e, j, k, l and m, and high in every other phase.
- R5: Line 2 is `cc_n[1]`. It is low in phases e through k inclusive, and high in every other phase.
- R6: Line 3 is `cc_n[2]`. It is low in phases h through o inclusive, and high in phases a through g.
- R7: On any enabled step with `term_n` high, at most one bit of `cc_n` changes. This includes the wrap from o to a.
- R8: An enabled edge with `term_n` low puts the sequencer in phase a, whatever phase it was in.
- R9: `cycle_end` is high for exactly the one cycle that follows an enabled edge which left phase o, or which terminated from any phase other than a. In every other cycle it is low. A termination taken while already in phase a gives no pulse.
- R10: Exactly one bit of `phase_oh` is set in every cycle after reset.
- R11: When `term_n` is low but `adv_en` is low, the request has no effect. The phase is held and no pulse is produced.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| adv_en | input | 1 | Phase-advance enable |
| term_n | input | 1 | Terminate request, active low |
| cc_n | output | 3 | Cycle-control lines, active low; bit 0 is line 1 |
| phase_oh | output | 15 | One-hot phase, bit 0 is phase a |
| cycle_end | output | 1 | One-cycle end-of-cycle pulse |

## Verification
The assertions check four things on every clock:
- the phase vector stays one-hot;
- the phase holds whenever the enable is low;
- normal steps shift the one-hot bit by one place, and terminated steps land in phase a;
- a normal step never changes more than one control line, and any end pulse coincides with phase a.

The exact line pattern for each of the fifteen phases comes only from the bench's sweeps. So does termination from every phase, including the no-pulse case in phase a, along with terminate requests ignored under a low enable and the irregular enable patterns.

// File: rtl/mcycle_seq_pkg.sv
package mcycle_seq_pkg;
  localparam int PHASES = 15;
  localparam int LINES  = 3;
  // Phase-set masks, one per line; bit i set means the line is asserted in phase i.
  localparam logic [PHASES-1:0] L1_SET = 15'h1E1E;  // b-e, j-m
  localparam logic [PHASES-1:0] L2_SET = 15'h07F0;  // e-k
  localparam logic [PHASES-1:0] L3_SET = 15'h7F80;  // h-o
  localparam logic [LINES*PHASES-1:0] LINE_SETS = {L3_SET, L2_SET, L1_SET};
  typedef logic [PHASES-1:0] phase_vec_t;
endpackage

// File: rtl/mcycle_ring.sv
module mcycle_ring #(
  parameter int N = mcycle_seq_pkg::PHASES
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         adv_en,
  input  logic         term_n,
  output logic [N-1:0] phase_q
);
  localparam logic [N-1:0] START = {{(N-1){1'b0}}, 1'b1};

  logic [N-1:0] rotated;
  assign rotated = {phase_q[N-2:0], phase_q[N-1]};

  always_ff @(posedge clk) begin
    if (rst)
      phase_q <= START;
    else if (adv_en)
      phase_q <= term_n ? rotated : START;
  end
endmodule

// File: rtl/mcycle_line_dec.sv
module mcycle_line_dec #(
  parameter int N = mcycle_seq_pkg::PHASES,
  parameter int L = mcycle_seq_pkg::LINES,
  parameter logic [L*N-1:0] SETS = mcycle_seq_pkg::LINE_SETS
) (
  input  logic [N-1:0] phase,
  output logic [L-1:0] lines_n
);
  for (genvar g = 0; g < L; g++) begin : g_line
    assign lines_n[g] = ~(|(phase & SETS[g*N +: N]));
  end
endmodule

// File: rtl/mcycle_end_pulse.sv
module mcycle_end_pulse #(
  parameter int N = mcycle_seq_pkg::PHASES
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         adv_en,
  input  logic         term_n,
  input  logic [N-1:0] phase,
  output logic         pulse_q
);
  logic leaving;
  assign leaving = term_n ? phase[N-1] : ~phase[0];

  always_ff @(posedge clk) begin
    if (rst)
      pulse_q <= 1'b0;
    else
      pulse_q <= adv_en & leaving;
  end
endmodule

// File: rtl/mcycle_seq.sv
module mcycle_seq #(
  parameter int N = mcycle_seq_pkg::PHASES,
  parameter int L = mcycle_seq_pkg::LINES
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         adv_en,
  input  logic         term_n,
  output logic [L-1:0] cc_n,
  output logic [N-1:0] phase_oh,
  output logic         cycle_end
);
  logic [N-1:0] phase_q;

  mcycle_ring #(.N(N)) u_ring (
    .clk(clk), .rst(rst), .adv_en(adv_en), .term_n(term_n), .phase_q(phase_q)
  );

  mcycle_line_dec #(.N(N), .L(L)) u_dec (
    .phase(phase_q), .lines_n(cc_n)
  );

  mcycle_end_pulse #(.N(N)) u_end (
    .clk(clk), .rst(rst), .adv_en(adv_en), .term_n(term_n),
    .phase(phase_q), .pulse_q(cycle_end)
  );

  assign phase_oh = phase_q;
endmodule

// File: rtl/mcycle_seq_chk.sv
module mcycle_seq_chk #(
  parameter int N = mcycle_seq_pkg::PHASES,
  parameter int L = mcycle_seq_pkg::LINES
) (
  input logic         clk,
  input logic         rst,
  input logic         adv_en,
  input logic         term_n,
  input logic [L-1:0] cc_n,
  input logic [N-1:0] phase_oh,
  input logic         cycle_end
);
  // R10: one-hot phase after reset
  a_r10_onehot: assert property (@(posedge clk) disable iff (rst)
    $countones(phase_oh) == 1);

  // R2 / R11: no enable, no movement
  a_r2_hold: assert property (@(posedge clk) disable iff (rst)
    !adv_en |=> $stable(phase_oh));

  a_r11_no_pulse_idle: assert property (@(posedge clk) disable iff (rst)
    !adv_en |=> !cycle_end);

  // R3: normal step moves one place forward
  a_r3_step: assert property (@(posedge clk) disable iff (rst)
    (adv_en && term_n && !phase_oh[N-1]) |=> phase_oh == ($past(phase_oh) << 1));

  a_r3_wrap: assert property (@(posedge clk) disable iff (rst)
    (adv_en && term_n && phase_oh[N-1]) |=> phase_oh[0]);

  // R7: single line change per normal step
  a_r7_one_line: assert property (@(posedge clk) disable iff (rst)
    (adv_en && term_n) |=> $countones(cc_n ^ $past(cc_n)) <= 1);

  // R8: termination lands in phase a
  a_r8_term: assert property (@(posedge clk) disable iff (rst)
    (adv_en && !term_n) |=> phase_oh[0]);

  // R9: pulse only alongside phase a
  a_r9_pulse_at_a: assert property (@(posedge clk) disable iff (rst)
    cycle_end |-> phase_oh[0]);
endmodule

bind mcycle_seq mcycle_seq_chk #(.N(N), .L(L)) u_chk (.*);

// File: tb/mcycle_seq_bench.sv
module mcycle_seq_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        adv_en = 1'b0;
  logic        term_n = 1'b1;
  logic [2:0]  cc_n;
  logic [14:0] phase_oh;
  logic        cycle_end;

  int total = 0;
  int bad = 0;
  int p = 0;          // model phase index
  logic exp_end = 1'b0;
  logic [2:0] last_cc = 3'b111;

  always #10 clk = ~clk;

  mcycle_seq u_mcycle_seq (
    .clk(clk), .rst(rst), .adv_en(adv_en), .term_n(term_n),
    .cc_n(cc_n), .phase_oh(phase_oh), .cycle_end(cycle_end)
  );

  function automatic logic [2:0] exp_cc(int ph);
    logic l1, l2, l3;
    l1 = (ph >= 1 && ph <= 4) || (ph >= 9 && ph <= 12);
    l2 = (ph >= 4 && ph <= 10);
    l3 = (ph >= 7);
    return ~{l3, l2, l1};
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h (phase %0d)", req, act, exp, p);
    end
  endtask

  task automatic tick(logic en, logic tn);
    int prev;
    logic normal;
    adv_en = en;
    term_n = tn;
    last_cc = cc_n;
    @(posedge clk);
    prev = p;
    normal = en && tn;
    exp_end = 1'b0;
    if (en) begin
      if (!tn) begin
        p = 0;
        exp_end = (prev != 0);
      end else if (prev == 14) begin
        p = 0;
        exp_end = 1'b1;
      end else begin
        p = prev + 1;
      end
    end
    @(negedge clk);
    chk(en ? (tn ? "R3" : "R8") : (tn ? "R2" : "R11"), 32'(phase_oh), 32'(15'h1 << p));
    chk("R4", 32'(cc_n[0]), 32'(exp_cc(p)[0]));
    chk("R5", 32'(cc_n[1]), 32'(exp_cc(p)[1]));
    chk("R6", 32'(cc_n[2]), 32'(exp_cc(p)[2]));
    chk("R9", 32'(cycle_end), 32'(exp_end));
    chk("R10", 32'($countones(phase_oh)), 32'd1);
    if (normal)
      chk("R7", 32'($countones(cc_n ^ last_cc) <= 1), 32'd1);
  endtask

  initial begin
    #(20 * 150000);
    bad++;
    total++;
    $display("FAIL watchdog act=running exp=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R1: reset state
    p = 0;
    chk("R1", 32'(phase_oh), 32'h1);
    chk("R1", 32'(cc_n), 32'h7);
    chk("R1", 32'(cycle_end), 32'h0);
    // R3/R4/R5/R6/R7: two full cycles, wrap included
    for (int i = 0; i < 30; i++) tick(1'b1, 1'b1);
    // R2: irregular enable pattern
    for (int i = 0; i < 60; i++) tick((i % 3) != 1, 1'b1);
    // R8/R9: terminate from every phase, including phase a
    for (int k = 0; k < 15; k++) begin
      while (p != k) tick(1'b1, 1'b1);
      tick(1'b1, 1'b0);
      tick(1'b0, 1'b1);
    end
    // R11: terminate without enable in every phase
    for (int k = 0; k < 15; k++) begin
      tick(1'b0, 1'b0);
      tick(1'b1, 1'b1);
    end
    // R1 again: reset from the middle of a cycle
    while (p != 9) tick(1'b1, 1'b1);
    rst = 1'b1;
    @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    p = 0;
    chk("R1", 32'(phase_oh), 32'h1);
    chk("R1", 32'(cc_n), 32'h7);
    chk("R1", 32'(cycle_end), 32'h0);
    for (int i = 0; i < 16; i++) tick(1'b1, 1'b1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule